// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers asynchronous serial characters from one or two receive pins. A one-cycle enable pulse `tick_i`, supplied from outside at sixteen times the bit rate, paces the receiver. Enabled pins are combined into one line by a logical AND, and a pin that is not enabled counts as idle high. The combined line can be inverted, and it then passes through a two-stage synchronizer. A start bit begins on a high-to-low transition of the line. Every bit of the frame is decided by a majority vote of three samples taken around the bit centre.

Characters carry 7 or 8 data bits, least significant bit first, and an optional odd or even parity bit. When the stop bit has been sampled, the block pulses an interrupt request for one cycle. In that same cycle it loads the data register and the three error flags. Software releases the data register by pulsing `rearm_i`. If a character completes while the register has not been released, the overrun flag is set and the earlier character is replaced.

Top module: `serial_rx_unit`

## Requirements
- R1: While `rx_en_i` is 0 the receiver stays idle: `busy_o` reads 0, no `irq_o` pulse occurs, and a frame in progress is abandoned.
- R2: The receive line is the AND of all enabled pins. A pin whose enable bit is 0 is treated as 1 whatever its level.
- R3: With `invert_i` at 1 the combined line is inverted before any other processing, so the idle level at the pins is 0.
- R4: A start bit whose vote at its centre is 1 is rejected. The receiver returns to idle and produces no character.
- R5: Each bit value is the majority of the line samples at oversample counts 7, 8 and 9, where count 0 is the first tick of the bit. A single disturbed sample does not change the result.
- R6: A pulse on `rearm_i` marks the data register as free, and the register is free after reset. If a character completes while the register is not free, `ovr_err_o` reads 1. Otherwise it reads 0. Either way the new character is stored.
- R7: With `par_en_i` at 1, one parity bit follows the data bits. With `par_odd_i` at 1 the data bits plus the parity bit must hold an odd number of ones, and with `par_odd_i` at 0 an even number. `par_err_o` reads 1 when this fails. With `par_en_i` at 0, `par_err_o` reads 0.
- R8: `frm_err_o` reads 1 when the stop bit votes 0, and 0 when it votes 1.
- R9: `busy_o` reads 1 from the cycle after a start bit is detected until the frame completes or is rejected.
- R10: With `len_full_i` at 1 a character has 8 data bits, and with 0 it has 7. The first data bit received lands in bit 0 of `data_o`. For 7-bit characters bit 7 of `data_o` reads 0.
- R11: `irq_o` is a one-cycle pulse for each completed character. `data_o` and the three error flags take their new values in the same cycle and hold them until the next character completes.
- R12: A start bit is taken only on a high-to-low transition of the line. A line that stays low after a frame, for example after a missing stop bit, does not start a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample enable pulse, 16 per bit |
| rx_en_i | input | 1 | Receiver enable |
| pin_en_i | input | 2 | Per-pin enable |
| rxd_i | input | 2 | Serial receive pins |
| invert_i | input | 1 | Invert combined line |
| len_full_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| rearm_i | input | 1 | Pulse: data register may be overwritten |
| data_o | output | 8 | Last received character |
| busy_o | output | 1 | Frame in progress |
| irq_o | output | 1 | One-cycle pulse on completed character |
| ovr_err_o | output | 1 | Character arrived before re-arm |
| par_err_o | output | 1 | Parity mismatch on last character |
| frm_err_o | output | 1 | Stop bit missing on last character |

## Verification
The assertions take for granted that character length, parity settings and pin enables stay constant while a frame is in progress. They also assume `tick_i` is a single-cycle pulse spaced at least three clocks apart, and that `rearm_i` never lands in the cycle a character completes. The bench changes pin levels only at the falling clock edge right after a tick, which lets the synchronized line reach the receiver before the next tick. Configuration is changed only between frames, with idle time in between, and re-arm pulses are issued only while the receiver is idle. Random characters and random format settings are mixed with directed cases: a single-sample glitch, a short start pulse, a bad parity bit, a low stop bit, overrun, the AND of two pins, and inversion.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_line_cond.sv
module rx_line_cond #(
  parameter int NPINS = 2,
  parameter int SYNC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_en_i,
  input  logic [NPINS-1:0] pin_i,
  input  logic             invert_i,
  output logic             line_o
);
  logic [NPINS-1:0] gated;
  logic             merged;
  logic [SYNC-1:0]  sync_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign gated[i] = pin_i[i] | ~pin_en_i[i];
  end

  assign merged = (&gated) ^ invert_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC-2:0], merged};
  end

  assign line_o = sync_q[SYNC-1];
endmodule

// File: rtl/rx_vote.sv
module rx_vote #(
  parameter int OSR = 16,
  localparam int CW = $clog2(OSR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          active_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          line_i,
  output logic          valid_o,
  output logic          vote_o
);
  localparam int MID = OSR / 2;
  localparam logic [CW-1:0] C_A = CW'(MID - 1);
  localparam logic [CW-1:0] C_B = CW'(MID);
  localparam logic [CW-1:0] C_C = CW'(MID + 1);

  logic s_a_q, s_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_a_q <= 1'b1;
      s_b_q <= 1'b1;
    end else if (tick_i && active_i) begin
      if (cnt_i == C_A) s_a_q <= line_i;
      if (cnt_i == C_B) s_b_q <= line_i;
    end
  end

  assign valid_o = tick_i && active_i && (cnt_i == C_C);
  assign vote_o  = (s_a_q & s_b_q) | (s_a_q & line_i) | (s_b_q & line_i);
endmodule

// File: rtl/rx_fsm.sv
module rx_fsm
  import rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8,
  localparam int CW = $clog2(OSR),
  localparam int IW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          line_i,
  input  logic          len_full_i,
  input  logic          par_en_i,
  input  logic          vote_valid_i,
  input  logic          vote_i,
  output logic [CW-1:0] cnt_o,
  output logic          active_o,
  output logic          done_o,
  output logic [DW-1:0] shift_o,
  output logic          pbit_o
);
  localparam logic [CW-1:0] C_END = CW'(OSR - 1);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q, idx_last;
  logic          prev_q;
  logic [DW-1:0] sh_q;
  logic          pbit_q;
  logic          bit_end;

  assign idx_last = len_full_i ? IW'(DW - 1) : IW'(DW - 2);
  assign bit_end  = tick_i && (cnt_q == C_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      prev_q  <= 1'b0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
    end else begin
      if (tick_i) prev_q <= line_i;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else begin
        if (state_q != ST_IDLE && tick_i) cnt_q <= (cnt_q == C_END) ? '0 : cnt_q + 1'b1;
        unique case (state_q)
          ST_IDLE: if (tick_i && prev_q && !line_i) begin
            state_q <= ST_START;
            cnt_q   <= CW'(1);
          end
          ST_START: begin
            if (vote_valid_i && vote_i) state_q <= ST_IDLE;
            else if (bit_end) begin
              state_q <= ST_DATA;
              idx_q   <= '0;
            end
          end
          ST_DATA: begin
            if (vote_valid_i) sh_q <= {vote_i, sh_q[DW-1:1]};
            if (bit_end) begin
              if (idx_q == idx_last) state_q <= par_en_i ? ST_PAR : ST_STOP;
              else idx_q <= idx_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (vote_valid_i) pbit_q <= vote_i;
            if (bit_end) state_q <= ST_STOP;
          end
          ST_STOP: if (vote_valid_i) state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign active_o = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_STOP) && vote_valid_i && en_i;
  assign shift_o  = sh_q;
  assign pbit_o   = pbit_q;

  assert_disabled_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !active_o);
  assert_start_reject_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && vote_valid_i && vote_i) |=> state_q == ST_IDLE);
  assert_busy_on_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_IDLE && tick_i && prev_q && !line_i) |=> active_o);
  assert_edge_start_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !prev_q) |=> state_q == ST_IDLE);
endmodule

// File: rtl/rx_result.sv
module rx_result #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [DW-1:0] shift_i,
  input  logic          pbit_i,
  input  logic          stop_i,
  input  logic          len_full_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          rearm_i,
  output logic [DW-1:0] data_o,
  output logic          irq_o,
  output logic          ovr_err_o,
  output logic          par_err_o,
  output logic          frm_err_o
);
  logic [DW-1:0] word;
  logic          perr;
  logic          free_q;

  assign word = len_full_i ? shift_i : {1'b0, shift_i[DW-1:1]};
  assign perr = par_en_i & ((^word) ^ pbit_i ^ par_odd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      irq_o     <= 1'b0;
      ovr_err_o <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      free_q    <= 1'b1;
    end else begin
      irq_o <= done_i;
      if (done_i) begin
        data_o    <= word;
        ovr_err_o <= ~(free_q | rearm_i);
        par_err_o <= perr;
        frm_err_o <= ~stop_i;
        free_q    <= 1'b0;
      end else if (rearm_i) begin
        free_q <= 1'b1;
      end
    end
  end

  assert_irq_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  assert_overrun_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !free_q && !rearm_i) |=> ovr_err_o);
  assert_short_msb_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !len_full_i) |-> !data_o[DW-1]);
  assert_par_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !par_en_i) |-> !par_err_o);
  assert_flags_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(data_o) && $stable(frm_err_o));
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit #(
  parameter int NPINS = 2,
  parameter int OSR   = 16,
  parameter int DW    = 8,
  parameter int SYNC  = 2,
  localparam int CW   = $clog2(OSR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rx_en_i,
  input  logic [NPINS-1:0] pin_en_i,
  input  logic [NPINS-1:0] rxd_i,
  input  logic             invert_i,
  input  logic             len_full_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic             rearm_i,
  output logic [DW-1:0]    data_o,
  output logic             busy_o,
  output logic             irq_o,
  output logic             ovr_err_o,
  output logic             par_err_o,
  output logic             frm_err_o
);
  logic          line;
  logic [CW-1:0] cnt;
  logic          active, done, vote_valid, vote, pbit;
  logic [DW-1:0] shift;

  rx_line_cond #(.NPINS(NPINS), .SYNC(SYNC)) u_line (
    .clk_i, .rst_ni, .pin_en_i, .pin_i(rxd_i), .invert_i, .line_o(line)
  );

  rx_vote #(.OSR(OSR)) u_vote (
    .clk_i, .rst_ni, .tick_i, .active_i(active), .cnt_i(cnt), .line_i(line),
    .valid_o(vote_valid), .vote_o(vote)
  );

  rx_fsm #(.OSR(OSR), .DW(DW)) u_fsm (
    .clk_i, .rst_ni, .tick_i, .en_i(rx_en_i), .line_i(line), .len_full_i,
    .par_en_i, .vote_valid_i(vote_valid), .vote_i(vote), .cnt_o(cnt),
    .active_o(active), .done_o(done), .shift_o(shift), .pbit_o(pbit)
  );

  rx_result #(.DW(DW)) u_res (
    .clk_i, .rst_ni, .done_i(done), .shift_i(shift), .pbit_i(pbit), .stop_i(vote),
    .len_full_i, .par_en_i, .par_odd_i, .rearm_i, .data_o, .irq_o,
    .ovr_err_o, .par_err_o, .frm_err_o
  );

  assign busy_o = active;
endmodule

// File: tb/sim_serial_rx_unit.sv
module sim_serial_rx_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rx_en = 1'b1;
  logic [1:0] pin_en = 2'b01;
  logic [1:0] rxd = 2'b11;
  logic       inv = 1'b0;
  logic       len_full = 1'b1;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rearm = 1'b0;
  logic [7:0] data;
  logic       busy, irq, ovr, perr, ferr;

  int checks = 0, errors = 0, irq_cnt = 0, tdiv = 0;
  bit pin1_low = 1'b0;
  logic busy_mid;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  serial_rx_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_en_i(rx_en), .pin_en_i(pin_en),
    .rxd_i(rxd), .invert_i(inv), .len_full_i(len_full), .par_en_i(par_en),
    .par_odd_i(par_odd), .rearm_i(rearm), .data_o(data), .busy_o(busy), .irq_o(irq),
    .ovr_err_o(ovr), .par_err_o(perr), .frm_err_o(ferr)
  );

  always @(negedge clk) begin
    tdiv = (tdiv == 3) ? 0 : tdiv + 1;
    tick <= (tdiv == 0) && rst_n;
    if (irq) irq_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    @(posedge clk);
    while (!tick) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_line(input logic l0, input logic l1);
    rxd[0] = l0 ^ inv;
    rxd[1] = pin1_low ? 1'b0 : (l1 ^ inv);
  endtask

  function automatic logic [7:0] exp_word(input logic [7:0] d);
    return len_full ? d : {1'b0, d[6:0]};
  endfunction

  function automatic logic par_bit(input logic [7:0] d);
    return (^exp_word(d)) ^ par_odd;
  endfunction

  task automatic rearm_pulse();
    @(negedge clk) rearm = 1'b1;
    @(negedge clk) rearm = 1'b0;
  endtask

  // glitch: frame bit index whose sample at count 8 is flipped on pin 0 (-1: none)
  task automatic send(input logic [7:0] d0, input logic [7:0] d1, input bit corrupt,
                      input bit badstop, input int glitch);
    logic [11:0] f0, f1;
    int n, nb;
    n = len_full ? 8 : 7;
    f0 = '0; f1 = '0;
    for (int k = 0; k < n; k++) begin
      f0[k+1] = d0[k];
      f1[k+1] = d1[k];
    end
    nb = n + 1;
    if (par_en) begin
      f0[nb] = par_bit(d0) ^ corrupt;
      f1[nb] = par_bit(d1);
      nb++;
    end
    f0[nb] = ~badstop;
    f1[nb] = 1'b1;
    nb++;
    wait_tick();
    for (int k = 0; k < nb; k++) begin
      set_line(f0[k], f1[k]);
      if (k == glitch) begin
        repeat (8) wait_tick();
        set_line(~f0[k], f1[k]);
        wait_tick();
        set_line(f0[k], f1[k]);
        repeat (7) wait_tick();
      end else begin
        repeat (16) wait_tick();
      end
      if (k == 1) busy_mid = busy;
    end
    set_line(1'b1, 1'b1);
    repeat (24) wait_tick();
  endtask

  initial begin
    int base;
    logic [7:0] d;
    void'($urandom(32'd1357));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R9 busy after reset", busy, 0);
    check("R11 irq after reset", irq, 0);
    check("R11 data after reset", data, 0);
    check("R6 ovr after reset", ovr, 0);
    check("R8 ferr after reset", ferr, 0);
    repeat (20) wait_tick();

    // R1: disabled receiver ignores a frame
    rx_en = 1'b0;
    base = irq_cnt;
    send(8'hA5, 8'hFF, 0, 0, -1);
    check("R1 no irq when disabled", irq_cnt - base, 0);
    check("R1 no busy when disabled", busy_mid, 0);
    rx_en = 1'b1;

    // basic 8-bit
    rearm_pulse();
    base = irq_cnt;
    send(8'h53, 8'hFF, 0, 0, -1);
    check("R10 8-bit data", data, 8'h53);
    check("R9 busy during frame", busy_mid, 1);
    check("R11 one irq per char", irq_cnt - base, 1);
    check("R9 idle after frame", busy, 0);

    // 7-bit
    len_full = 1'b0;
    rearm_pulse();
    send(8'hD3, 8'hFF, 0, 0, -1);
    check("R10 7-bit msb zero", data, 8'h53);
    len_full = 1'b1;

    // parity
    par_en = 1'b1;
    for (int m = 0; m < 4; m++) begin
      par_odd = m[1];
      rearm_pulse();
      send(8'h6C, 8'hFF, m[0], 0, -1);
      check("R7 parity flag", perr, m[0]);
      check("R7 data with parity", data, 8'h6C);
    end
    par_en = 1'b0;

    // framing error, then line held low must not start a frame
    rearm_pulse();
    base = irq_cnt;
    send(8'h3C, 8'hFF, 0, 1, -1);
    check("R8 framing flag", ferr, 1);
    check("R12 no restart on held-low line", irq_cnt - base, 1);
    rearm_pulse();
    send(8'h3D, 8'hFF, 0, 0, -1);
    check("R8 framing clears", ferr, 0);

    // overrun
    rearm_pulse();
    send(8'h11, 8'hFF, 0, 0, -1);
    check("R6 no overrun when rearmed", ovr, 0);
    send(8'h22, 8'hFF, 0, 0, -1);
    check("R6 overrun without rearm", ovr, 1);
    check("R6 new char stored", data, 8'h22);
    rearm_pulse();
    send(8'h33, 8'hFF, 0, 0, -1);
    check("R6 overrun clears", ovr, 0);

    // R5: single-sample glitch at centre of data bit 3 (frame index 4)
    rearm_pulse();
    send(8'hF0, 8'hFF, 0, 0, 4);
    check("R5 glitch rejected", data, 8'hF0);
    rearm_pulse();
    send(8'h0F, 8'hFF, 0, 0, 2);
    check("R5 glitch rejected high bit", data, 8'h0F);

    // R4: short start pulse
    base = irq_cnt;
    wait_tick();
    set_line(1'b0, 1'b1);
    repeat (6) wait_tick();
    set_line(1'b1, 1'b1);
    repeat (30) wait_tick();
    check("R4 false start no irq", irq_cnt - base, 0);
    check("R4 false start idle", busy, 0);

    // R2: pins ANDed; disabled pin ignored
    pin_en = 2'b11;
    rearm_pulse();
    send(8'hB6, 8'h5D, 0, 0, -1);
    check("R2 AND of two pins", data, 8'hB6 & 8'h5D);
    pin_en = 2'b01;
    pin1_low = 1'b1;
    set_line(1'b1, 1'b1);
    rearm_pulse();
    send(8'hC9, 8'h00, 0, 0, -1);
    check("R2 disabled pin ignored", data, 8'hC9);
    pin1_low = 1'b0;
    set_line(1'b1, 1'b1);

    // R3: inverted line
    @(negedge clk);
    inv = 1'b1;
    set_line(1'b1, 1'b1);
    repeat (20) wait_tick();
    rearm_pulse();
    send(8'h9A, 8'hFF, 0, 0, -1);
    check("R3 inverted input", data, 8'h9A);
    check("R3 inverted no framing error", ferr, 0);
    inv = 1'b0;
    set_line(1'b1, 1'b1);
    repeat (20) wait_tick();

    // random frames
    for (int i = 0; i < 16; i++) begin
      len_full = $urandom_range(0, 1);
      par_en   = $urandom_range(0, 1);
      par_odd  = $urandom_range(0, 1);
      d = 8'($urandom);
      rearm_pulse();
      base = irq_cnt;
      send(d, 8'hFF, 0, 0, -1);
      check("R10 random data", data, exp_word(d));
      check("R7 random parity ok", perr, 0);
      check("R8 random stop ok", ferr, 0);
      check("R11 random irq", irq_cnt - base, 1);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule